// File: doc/BRIEF.md
# Absorber position changer controller

This block steers a five-position mechanical absorber selector from a small register file. Five position-feedback lines from the selector pass through a two-flop synchronizer. They can be read at any time in the low bits of a read-only status word. Software loads a set register and then issues a copy command through the control register. The five low bits of the set register then appear on the five position-select outputs, and they stay there until the next copy command.

Two enable ticks are derived from the system clock by counting. A slow tick, one per second at the default 40 MHz clock, advances a seconds counter while the run bit of the control register is 1. When the counter reaches the programmed change time, the block pulses a trigger output for one cycle and sets a sticky change-due flag. The flag can be seen as an output and as status bit 8. A faster tick, 25 kHz by default, is brought out for external time-stamp overflow monitoring. Neither tick is used as a clock.

Register byte offsets: change time at 0x200, control at 0x204, status at 0x208, set at 0x20C. Writes use a single-cycle `wr_en` strobe, and reads are combinational from `addr`.

Top module: `abspos_ctrl`

## Requirements
- R1: Status bits 4..0 show `pos_fb_i` delayed by two clock edges (two-flop synchronizer). Status bits 7..5 read 0.
- R2: The status register at 0x208 is read-only. A write to it changes no register and no output.
- R3: A write to control (0x204) with data bit 0 = 1 loads set-register bits 4..0 onto `pos_sel_o` at the next edge. At any other time `pos_sel_o` holds its value. Control bit 0 reads back as 0.
- R4: While control bit 1 (run) is 0, the seconds counter is held at zero and `due_o` and `trig_o` are 0.
- R5: While run is 1 and `due_o` is 0, each slow tick adds one to the seconds counter. The edge at which the count reaches the change time (N ≥ 1) sets `due_o` and raises `trig_o` for exactly one cycle. `due_o` then stays 1 and counting stops until run is cleared.
- R6: A change time of 0 never sets `due_o`.
- R7: `sec_tick_o` is a one-cycle pulse every SEC_DIV cycles. `fast_tick_o` is a one-cycle pulse every FAST_DIV cycles.
- R8: After reset all registers read 0. Change time reads back all 32 bits, set reads back 8 bits, control reads back bit 1, and status bit 8 equals `due_o`. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| pos_fb_i | input | NPOS | Position feedback from selector |
| pos_sel_o | output | NPOS | Position-select drive |
| trig_o | output | 1 | One-cycle change trigger |
| due_o | output | 1 | Change time reached flag |
| sec_tick_o | output | 1 | Slow (1 Hz) enable pulse |
| fast_tick_o | output | 1 | Fast (25 kHz) enable pulse |

## Verification
The bench targets these corner cases:
- A change time of 0. A design that compared without a guard would raise the flag on the first wrap or at once.
- A change time written below the current count while the timer runs. A design with a `>=` test would fire early.
- Clearing run while the flag is set. A design with a leaky flag would keep it set, or would restart counting from a stale value.
- Control writes with bit 0 clear, and writes to the status word. Both must leave the select outputs and all registers unchanged. A design that decoded a write loosely would move the selector.
- Tick spacing, measured exactly. An off-by-one divider shows up as a period error.

// File: rtl/abspos_pkg.sv
package abspos_pkg;
  localparam int unsigned OFS_TIME   = 32'h200;
  localparam int unsigned OFS_CTRL   = 32'h204;
  localparam int unsigned OFS_STATUS = 32'h208;
  localparam int unsigned OFS_SET    = 32'h20C;

  localparam int unsigned CTRL_COPY_BIT = 0;
  localparam int unsigned CTRL_RUN_BIT  = 1;
  localparam int unsigned STAT_DUE_BIT  = 8;

  // count reaches programmed limit; limit 0 never matches
  function automatic logic limit_hit(input logic [31:0] nxt, input logic [31:0] lim);
    return (lim != 32'd0) && (nxt == lim);
  endfunction

  function automatic logic [31:0] pack_status(input logic due, input logic [4:0] fb);
    logic [31:0] w;
    w = '0;
    w[4:0] = fb;
    w[STAT_DUE_BIT] = due;
    return w;
  endfunction
endpackage

// File: rtl/abspos_tick_div.sv
module abspos_tick_div #(
  parameter int unsigned DIV = 40_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + CW'(1);
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/abspos_sync2.sv
module abspos_sync2 #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/abspos_sec_timer.sv
module abspos_sec_timer
  import abspos_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        tick,
  input  logic [31:0] limit,
  output logic        due,
  output logic        trig
);
  logic [31:0] secs_q;
  logic [31:0] secs_nxt;

  assign secs_nxt = secs_q + 32'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      secs_q <= '0;
      due    <= 1'b0;
      trig   <= 1'b0;
    end else begin
      trig <= 1'b0;
      if (!run) begin
        secs_q <= '0;
        due    <= 1'b0;
      end else if (tick && !due) begin
        secs_q <= secs_nxt;
        if (limit_hit(secs_nxt, limit)) begin
          due  <= 1'b1;
          trig <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/abspos_ctrl.sv
module abspos_ctrl
  import abspos_pkg::*;
#(
  parameter int unsigned AW       = 12,
  parameter int unsigned NPOS     = 5,
  parameter int unsigned SET_W    = 8,
  parameter int unsigned SEC_DIV  = 40_000_000,
  parameter int unsigned FAST_DIV = 1_600
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  input  logic [NPOS-1:0] pos_fb_i,
  output logic [NPOS-1:0] pos_sel_o,
  output logic            trig_o,
  output logic            due_o,
  output logic            sec_tick_o,
  output logic            fast_tick_o
);
  localparam logic [AW-1:0] A_TIME   = AW'(OFS_TIME);
  localparam logic [AW-1:0] A_CTRL   = AW'(OFS_CTRL);
  localparam logic [AW-1:0] A_STATUS = AW'(OFS_STATUS);
  localparam logic [AW-1:0] A_SET    = AW'(OFS_SET);

  logic [31:0]      chg_time_q;
  logic             run_q;
  logic [SET_W-1:0] set_q;
  logic [NPOS-1:0]  fb_sync;
  logic [NPOS-1:0]  sel_q;

  // named events for the checker
  logic copy_evt;
  logic wr_status;

  assign copy_evt  = wr_en && (addr == A_CTRL) && wdata[CTRL_COPY_BIT];
  assign wr_status = wr_en && (addr == A_STATUS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chg_time_q <= '0;
      run_q      <= 1'b0;
      set_q      <= '0;
    end else if (wr_en) begin
      case (addr)
        A_TIME: chg_time_q <= wdata;
        A_CTRL: run_q      <= wdata[CTRL_RUN_BIT];
        A_SET:  set_q      <= wdata[SET_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        sel_q <= '0;
    else if (copy_evt) sel_q <= set_q[NPOS-1:0];
  end
  assign pos_sel_o = sel_q;

  abspos_sync2 #(.W(NPOS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pos_fb_i),
    .q    (fb_sync)
  );

  abspos_tick_div #(.DIV(SEC_DIV)) u_sec_div (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (sec_tick_o)
  );

  abspos_tick_div #(.DIV(FAST_DIV)) u_fast_div (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (fast_tick_o)
  );

  abspos_sec_timer u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run_q),
    .tick (sec_tick_o),
    .limit(chg_time_q),
    .due  (due_o),
    .trig (trig_o)
  );

  logic [4:0] fb5;
  always_comb begin
    fb5 = '0;
    fb5[NPOS-1:0] = fb_sync;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_TIME:   rdata = chg_time_q;
      A_CTRL:   rdata[CTRL_RUN_BIT] = run_q;
      A_STATUS: rdata = pack_status(due_o, fb5);
      A_SET:    rdata[SET_W-1:0] = set_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/abspos_chk.sv
module abspos_chk #(
  parameter int unsigned NPOS = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run,
  input logic            due,
  input logic            trig,
  input logic            sec_tick,
  input logic            fast_tick,
  input logic            copy_evt,
  input logic [NPOS-1:0] pos_sel,
  input logic [31:0]     limit
);
  // R5: trigger lasts a single cycle
  a_r5_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  // R5: trigger only together with the flag
  a_r5_trig_with_due: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> due);

  // R5: flag is sticky while running
  a_r5_due_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (due && run) |=> due);

  // R4: idle timer clears the flag
  a_r4_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!due && !trig));

  // R6: flag never rises against a zero limit
  a_r6_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(due) |-> ($past(limit) != 32'd0));

  // R3: select outputs move only on a copy command
  a_r3_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_evt |=> $stable(pos_sel));

  // R7: ticks are single-cycle pulses
  a_r7_sec_single: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);
  a_r7_fast_single: assert property (@(posedge clk) disable iff (!rst_n)
    fast_tick |=> !fast_tick);
endmodule

bind abspos_ctrl abspos_chk #(.NPOS(NPOS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run_q),
  .due      (due_o),
  .trig     (trig_o),
  .sec_tick (sec_tick_o),
  .fast_tick(fast_tick_o),
  .copy_evt (copy_evt),
  .pos_sel  (pos_sel_o),
  .limit    (chg_time_q)
);

// File: tb/abspos_ctrl_tb_top.sv
`timescale 1ns/1ps
module abspos_ctrl_tb_top;
  localparam int unsigned SEC_DIV  = 25;
  localparam int unsigned FAST_DIV = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = 12'h208;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0]  pos_fb_i = '0;
  logic [4:0]  pos_sel_o;
  logic        trig_o, due_o, sec_tick_o, fast_tick_o;

  int n_chk = 0;
  int n_bad = 0;
  int n_trig = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  abspos_ctrl #(.SEC_DIV(SEC_DIV), .FAST_DIV(FAST_DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pos_fb_i(pos_fb_i), .pos_sel_o(pos_sel_o),
    .trig_o(trig_o), .due_o(due_o), .sec_tick_o(sec_tick_o),
    .fast_tick_o(fast_tick_o)
  );

  // reference state, advanced at each falling edge
  logic [31:0] m_time, m_secs;
  logic        m_run, m_due, m_trig;
  logic [7:0]  m_set;
  logic [4:0]  m_sel, m_fb1, m_fb2;
  longint      cyc = 0, last_sec = -1, last_fast = -1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    case (a)
      12'h200: return m_time;
      12'h204: return {30'd0, m_run, 1'b0};
      12'h208: return {23'd0, m_due, 3'd0, m_fb2};
      12'h20C: return {24'd0, m_set};
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit reaches(input logic [31:0] n, input logic [31:0] lim);
    return (lim != 0) && (n == lim);
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_time = 0; m_secs = 0; m_run = 0; m_due = 0; m_trig = 0;
      m_set = 0; m_sel = 0; m_fb1 = 0; m_fb2 = 0;
      last_sec = -1; last_fast = -1;
    end else begin
      // R1 R2 R8: read mux, R3: select, R4 R5 R6: flag and trigger
      chk((addr == 12'h208) ? "R1 status" : "R8 readback", rdata, exp_read(addr));
      chk("R3 pos_sel", {27'd0, pos_sel_o}, {27'd0, m_sel});
      chk("R5 trig", {31'd0, trig_o}, {31'd0, m_trig});
      chk("R5 due", {31'd0, due_o}, {31'd0, m_due});
      if (trig_o) n_trig++;
      if (sec_tick_o) begin
        if (last_sec >= 0) chk("R7 sec period", 32'(cyc - last_sec), SEC_DIV);
        last_sec = cyc;
      end
      if (fast_tick_o) begin
        if (last_fast >= 0) chk("R7 fast period", 32'(cyc - last_fast), FAST_DIV);
        last_fast = cyc;
      end
      // advance to next edge
      m_fb2 = m_fb1; m_fb1 = pos_fb_i;
      m_trig = 0;
      if (!m_run) begin
        m_secs = 0; m_due = 0;
      end else if (sec_tick_o && !m_due) begin
        m_secs = m_secs + 1;
        if (reaches(m_secs, m_time)) begin m_due = 1; m_trig = 1; end
      end
      if (wr_en) begin
        case (addr)
          12'h200: m_time = wdata;
          12'h204: begin m_run = wdata[1]; if (wdata[0]) m_sel = m_set[4:0]; end
          12'h20C: m_set = wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0; addr = 12'h208;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R8: reset values
    chk("R8 reset rdata", rdata, 32'd0);
    chk("R3 reset sel", {27'd0, pos_sel_o}, 32'd0);
    chk("R4 reset due", {31'd0, due_o}, 32'd0);

    // R3: copy and hold
    wr(12'h20C, 32'h0000_00E4);
    wr(12'h204, 32'd1);
    idle(1); @(negedge clk);
    chk("R3 copy", {27'd0, pos_sel_o}, 32'h04);
    wr(12'h20C, 32'h0000_0011);
    wr(12'h204, 32'd0);
    @(negedge clk);
    chk("R3 hold", {27'd0, pos_sel_o}, 32'h04);

    // R2: status write ignored
    wr(12'h208, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R2 status ro", {27'd0, pos_sel_o}, 32'h04);

    // R1: feedback
    @(posedge clk); #1 pos_fb_i = 5'b10110;
    idle(3); @(negedge clk);
    chk("R1 fb", rdata, 32'h16);

    // R5: three-second interval
    wr(12'h200, 32'd3);
    wr(12'h204, 32'd2);
    idle(4 * SEC_DIV); @(negedge clk);
    chk("R5 due set", {31'd0, due_o}, 32'd1);
    // R4: clearing run
    wr(12'h204, 32'd0);
    idle(1); @(negedge clk);
    chk("R4 cleared", {31'd0, due_o}, 32'd0);

    // R6: zero limit
    wr(12'h200, 32'd0);
    wr(12'h204, 32'd2);
    idle(5 * SEC_DIV); @(negedge clk);
    chk("R6 zero limit", {31'd0, due_o}, 32'd0);
    wr(12'h204, 32'd0);

    // randomized mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 6);
      case (op)
        0: begin @(posedge clk); #1 pos_fb_i = 5'($urandom); end
        1: wr(12'h200, 32'($urandom_range(0, 4)));
        2: wr(12'h204, 32'($urandom_range(0, 3)));
        3: wr(12'h20C, 32'($urandom));
        4: wr(12'h208, 32'($urandom));
        5: begin @(posedge clk); #1 addr = 12'h200 + 12'(4 * $urandom_range(0, 4)); end
        default: idle($urandom_range(1, 3 * SEC_DIV));
      endcase
    end
    idle(2); @(negedge clk);
    chk("R5 trigger seen", {31'd0, (n_trig > 0)}, 32'd1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule